// File: doc/BRIEF.md
# Bidirectional Port with Bit Set/Clear Sequencer

An 8-bit general-purpose I/O port controlled through three registers on a simple synchronous bus: a data latch, a per-pin direction mask and a per-pin option mask. Each pin leaves the block as a pad model of three signals (drive value, drive enable, pull-up enable). The option bit enables the pull-up when the pin is an input. When the pin is an output it chooses between push-pull and open-drain drive.

A read of the data register returns a mixed view. Output pins show their latch bit. Input pins show the pin level after a two-flop synchronizer. The port also accepts single-bit set and clear commands. A command runs in three clocked steps: it reads the data register through that mixed view, changes the one target bit, and writes all bits back to the latch. Input pins therefore copy their current pin level into the latch. That stored value appears on the pin if the bit is later turned into an output. Software avoids this by writing the data register before it changes a pin's direction.

Top module: `gpio_rmw_port`

## Requirements
- R1: After reset the data, direction and option registers read 0, pad_oe and pad_pu are all 0, busy is 0 and bus_ready is 1.
- R2: A read at bus_addr 0 returns, for each bit, the latch bit if the direction bit is 1 and the synchronized pin level if it is 0. A change on pad_in appears in that read after exactly two rising clock edges.
- R3: A bus write at bus_addr 0 loads all 8 latch bits, including input bits. When a bit becomes an output its pad drives the latch value from the next cycle.
- R4: A pin with direction 1 and option 1 (push-pull) has pad_oe 1 and pad_out equal to its latch bit.
- R5: A pin with direction 1 and option 0 (open-drain) has pad_out 0 and pad_oe equal to the inverse of its latch bit.
- R6: pad_pu equals the option bit for input pins and is 0 for output pins.
- R7: A command (cmd_valid with cmd_bit and cmd_set, 1 = set and 0 = clear) accepted while idle holds busy high for exactly 3 cycles. At the end it loads the latch with the data-register read view taken in the first busy cycle, with only the target bit forced to cmd_set.
- R8: While busy is 1, bus_ready is 0 and a pending bus write has no effect. The write is applied on the first edge after busy falls, provided bus_wr is still held.
- R9: cmd_valid raised while busy is 1 is ignored.
- R10: A bus write and a command presented together while idle both take effect. The write is applied first, and the command's read step sees the written value.
- R11: Bus addresses are 0 = data, 1 = direction, 2 = option. Address 3 reads 0 and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write request, held until accepted |
| bus_addr | input | 2 | Register address (0 data, 1 direction, 2 option) |
| bus_wdata | input | 8 | Write data |
| bus_ready | output | 1 | A write is accepted on the edge where this is 1 |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| cmd_valid | input | 1 | Bit command strobe |
| cmd_set | input | 1 | 1 = set bit, 0 = clear bit |
| cmd_bit | input | 3 | Target bit index |
| busy | output | 1 | Command sequence in progress |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Pad drive value |
| pad_oe | output | 8 | Pad drive enable |
| pad_pu | output | 8 | Pad pull-up enable |

## Verification
Two functions can fall in the same cycle. A bus write and a bit command can arrive together while the port is idle. A bus write can also arrive while the sequencer is mid-command. The bench provokes the first by raising bus_wr and cmd_valid on the same edge, and it passes only if the latch ends up holding the written byte plus the commanded bit. For the second, it raises bus_wr one cycle after a command. It checks that bus_ready stays low and the direction register keeps its old value through all three busy cycles, and that the held write lands exactly one cycle after busy drops.

// File: rtl/gpio_rmw_pkg.sv
package gpio_rmw_pkg;

    localparam int unsigned REG_ADDR_W = 2;

    localparam logic [REG_ADDR_W-1:0] ADDR_DATA = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_DIR  = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_OPT  = 2'd2;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_READ   = 2'd1,
        SEQ_MODIFY = 2'd2,
        SEQ_WRITE  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_regs_t;

    sync_regs_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_in;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_out = s_q.stable;

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] latch,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] opt,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        always_comb begin
            pad_out[g] = 1'b0;
            pad_oe[g]  = 1'b0;
            pad_pu[g]  = 1'b0;
            if (dir[g]) begin
                if (opt[g]) begin
                    // push-pull: always driven
                    pad_oe[g]  = 1'b1;
                    pad_out[g] = latch[g];
                end else begin
                    // open-drain: sink only, release on 1
                    pad_oe[g]  = ~latch[g];
                    pad_out[g] = 1'b0;
                end
            end else begin
                pad_pu[g] = opt[g];
            end
        end
    end

endmodule

// File: rtl/gpio_rmw_seq.sv
module gpio_rmw_seq
    import gpio_rmw_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned BIT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_set,
    input  logic [BIT_W-1:0] cmd_bit,
    input  logic [WIDTH-1:0] rd_view,
    output logic             busy,
    output logic             wr_en,
    output logic [WIDTH-1:0] wr_value
);

    typedef struct packed {
        seq_state_e       state;
        logic [BIT_W-1:0] bit_idx;
        logic             set_val;
        logic [WIDTH-1:0] snap;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            SEQ_IDLE: begin
                if (cmd_valid) begin
                    r_d.state   = SEQ_READ;
                    r_d.bit_idx = cmd_bit;
                    r_d.set_val = cmd_set;
                end
            end
            SEQ_READ: begin
                r_d.snap  = rd_view;
                r_d.state = SEQ_MODIFY;
            end
            SEQ_MODIFY: begin
                r_d.snap[r_q.bit_idx] = r_q.set_val;
                r_d.state             = SEQ_WRITE;
            end
            SEQ_WRITE: begin
                r_d.state = SEQ_IDLE;
            end
            default: r_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: SEQ_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.state != SEQ_IDLE);
    assign wr_en    = (r_q.state == SEQ_WRITE);
    assign wr_value = r_q.snap;

endmodule

// File: rtl/gpio_rmw_port.sv
module gpio_rmw_port
    import gpio_rmw_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned BIT_W = $clog2(WIDTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]      bus_wdata,
    output logic                  bus_ready,
    output logic [WIDTH-1:0]      bus_rdata,
    input  logic                  cmd_valid,
    input  logic                  cmd_set,
    input  logic [BIT_W-1:0]      cmd_bit,
    output logic                  busy,
    input  logic [WIDTH-1:0]      pad_in,
    output logic [WIDTH-1:0]      pad_out,
    output logic [WIDTH-1:0]      pad_oe,
    output logic [WIDTH-1:0]      pad_pu
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] opt;
    } port_regs_t;

    port_regs_t p_d, p_q;

    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] rd_view;
    logic             seq_wr;
    logic [WIDTH-1:0] seq_value;
    logic             seq_busy;

    gpio_sync2 #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_sync)
    );

    // read multiplexer: outputs show the latch, inputs show the pin
    assign rd_view = (p_q.dir & p_q.data) | (~p_q.dir & pin_sync);

    gpio_rmw_seq #(.WIDTH(WIDTH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_set   (cmd_set),
        .cmd_bit   (cmd_bit),
        .rd_view   (rd_view),
        .busy      (seq_busy),
        .wr_en     (seq_wr),
        .wr_value  (seq_value)
    );

    assign busy      = seq_busy;
    assign bus_ready = ~seq_busy;

    always_comb begin
        p_d = p_q;
        if (bus_wr && bus_ready) begin
            unique case (bus_addr)
                ADDR_DATA: p_d.data = bus_wdata;
                ADDR_DIR:  p_d.dir  = bus_wdata;
                ADDR_OPT:  p_d.opt  = bus_wdata;
                default:   ;
            endcase
        end
        if (seq_wr) begin
            p_d.data = seq_value;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_DATA: bus_rdata = rd_view;
            ADDR_DIR:  bus_rdata = p_q.dir;
            ADDR_OPT:  bus_rdata = p_q.opt;
            default:   bus_rdata = '0;
        endcase
    end

    gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
        .latch   (p_q.data),
        .dir     (p_q.dir),
        .opt     (p_q.opt),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_pu  (pad_pu)
    );

endmodule

// File: rtl/gpio_rmw_port_chk.sv
module gpio_rmw_port_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             bus_ready,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_pu,
    input logic [WIDTH-1:0] data_q,
    input logic [WIDTH-1:0] dir_q,
    input logic [WIDTH-1:0] opt_q
);

    // R1
    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (data_q == '0 && dir_q == '0 && opt_q == '0 && !busy && bus_ready));

    // R4
    a_r4_pushpull_drives: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_q & opt_q & ~pad_oe) == '0) &&
        ((dir_q & opt_q & (pad_out ^ data_q)) == '0));

    // R5
    a_r5_opendrain_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_q & ~opt_q & pad_out) == '0) &&
        ((dir_q & ~opt_q & pad_oe & data_q) == '0));

    // R6
    a_r6_pullup_inputs_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & dir_q) == '0);

    // R7
    a_r7_busy_three_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy ##1 busy ##1 !busy);

    // R7
    a_r7_latch_held_mid_sequence: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> $stable(data_q) ##1 $stable(data_q));

    // R8
    a_r8_config_frozen_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(dir_q) && $stable(opt_q)));

endmodule

bind gpio_rmw_port gpio_rmw_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .bus_ready (bus_ready),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .data_q    (p_q.data),
    .dir_q     (p_q.dir),
    .opt_q     (p_q.opt)
);

// File: tb/gpio_rmw_port_tb.sv
module gpio_rmw_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_ready;
    logic [7:0] bus_rdata;
    logic       cmd_valid = 1'b0;
    logic       cmd_set = 1'b0;
    logic [2:0] cmd_bit = 3'd0;
    logic       busy;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out, pad_oe, pad_pu;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    gpio_rmw_port u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .cmd_valid(cmd_valid), .cmd_set(cmd_set), .cmd_bit(cmd_bit),
        .busy(busy), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        while (!bus_ready) @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic bit_cmd(input logic [2:0] b, input logic s);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_bit = b; cmd_set = s;
        @(negedge clk);
        cmd_valid = 1'b0;
        #1 check(busy == 1'b1, "R7 busy cycle 1", busy, 1);
        @(negedge clk); #1 check(busy == 1'b1, "R7 busy cycle 2", busy, 1);
        @(negedge clk); #1 check(busy == 1'b1, "R7 busy cycle 3", busy, 1);
        @(negedge clk); #1 check(busy == 1'b0, "R7 busy released", busy, 0);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_read(2'd1, v); check(v == 8'h00, "R1 dir reset", v, 0);
        bus_read(2'd2, v); check(v == 8'h00, "R1 opt reset", v, 0);
        bus_read(2'd0, v); check(v == 8'h00, "R1 data reset", v, 0);
        check(pad_oe == 8'h00, "R1 pad_oe reset", pad_oe, 0);
        check(pad_pu == 8'h00, "R1 pad_pu reset", pad_pu, 0);
        check(busy == 1'b0 && bus_ready == 1'b1, "R1 idle", {busy, bus_ready}, 2'b01);
    endtask

    task automatic t_read_mux();
        logic [7:0] v;
        bus_write(2'd1, 8'h0F);
        bus_write(2'd0, 8'h05);
        @(negedge clk); pad_in = 8'hAF;
        @(negedge clk); bus_addr = 2'd0; #1;
        check(bus_rdata[7:4] == 4'h0, "R2 sync not yet through", bus_rdata, 8'h05);
        @(negedge clk); #1;
        check(bus_rdata == 8'hA5, "R2 mixed read after two edges", bus_rdata, 8'hA5);
        bus_read(2'd0, v); check(v == 8'hA5, "R2 output pins show latch", v, 8'hA5);
    endtask

    task automatic t_drive_modes();
        bus_write(2'd2, 8'h0F);
        @(negedge clk); #1;
        check(pad_oe[3:0] == 4'hF, "R4 push-pull enable", pad_oe, 8'h0F);
        check(pad_out[3:0] == 4'h5, "R4 push-pull value", pad_out, 8'h05);
        bus_write(2'd2, 8'h00);
        @(negedge clk); #1;
        check(pad_oe[3:0] == 4'hA, "R5 open-drain enable", pad_oe, 8'h0A);
        check(pad_out == 8'h00, "R5 open-drain value", pad_out, 0);
    endtask

    task automatic t_pullup();
        bus_write(2'd2, 8'h3C);
        @(negedge clk); #1;
        check(pad_pu == 8'h30, "R6 pull-up on inputs only", pad_pu, 8'h30);
    endtask

    task automatic t_addr3();
        logic [7:0] v;
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, v); check(v == 8'h00, "R11 unused address", v, 0);
        bus_read(2'd1, v); check(v == 8'h0F, "R11 dir untouched", v, 8'h0F);
        bus_read(2'd2, v); check(v == 8'h3C, "R11 opt untouched", v, 8'h3C);
    endtask

    task automatic t_rmw_hazard();
        logic [7:0] v;
        bus_write(2'd1, 8'h0F);
        bus_write(2'd2, 8'hFF);
        bus_write(2'd0, 8'h00);
        @(negedge clk); pad_in = 8'hF0;
        repeat (3) @(negedge clk);
        bus_read(2'd0, v); check(v == 8'hF0, "R2 pulled-up inputs read high", v, 8'hF0);
        bit_cmd(3'd0, 1'b1);
        bus_write(2'd1, 8'hFF);
        @(negedge clk); #1;
        check(pad_out == 8'hF1, "R7 input bits captured pin level", pad_out, 8'hF1);
        check(pad_oe == 8'hFF, "R3 new outputs driven", pad_oe, 8'hFF);
        bit_cmd(3'd4, 1'b0);
        bus_read(2'd0, v); check(v == 8'hE1, "R7 clear one bit", v, 8'hE1);
    endtask

    task automatic t_write_inputs();
        logic [7:0] v;
        pad_in = 8'h00;
        bus_write(2'd1, 8'h00);
        bus_write(2'd0, 8'h5A);
        repeat (3) @(negedge clk);
        bus_read(2'd0, v); check(v == 8'h00, "R3 input read shows pins", v, 0);
        bus_write(2'd1, 8'hFF);
        @(negedge clk); #1;
        check(pad_out == 8'h5A, "R3 latch written while input", pad_out, 8'h5A);
    endtask

    task automatic t_stall();
        logic [7:0] v;
        bus_write(2'd0, 8'h00);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_bit = 3'd3; cmd_set = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h0F;
        #1 check(bus_ready == 1'b0, "R8 not ready cycle 1", bus_ready, 0);
        @(negedge clk); #1 check(bus_ready == 1'b0, "R8 not ready cycle 2", bus_ready, 0);
        @(negedge clk); #1 check(bus_ready == 1'b0, "R8 not ready cycle 3", bus_ready, 0);
        check(bus_rdata == 8'hFF, "R8 dir held while busy", bus_rdata, 8'hFF);
        @(negedge clk); #1 check(bus_ready == 1'b1, "R8 ready after command", bus_ready, 1);
        @(negedge clk); bus_wr = 1'b0; #1;
        check(bus_rdata == 8'h0F, "R8 held write applied", bus_rdata, 8'h0F);
        bus_read(2'd0, v); check(v == 8'h08, "R8 command result kept", v, 8'h08);
        bus_write(2'd1, 8'hFF);
    endtask

    task automatic t_cmd_ignored();
        logic [7:0] v;
        bus_write(2'd0, 8'h00);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_bit = 3'd6; cmd_set = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        @(negedge clk); cmd_valid = 1'b1; cmd_bit = 3'd2; cmd_set = 1'b1;
        @(negedge clk); cmd_valid = 1'b0;
        repeat (4) @(negedge clk);
        bus_read(2'd0, v); check(v == 8'h40, "R9 command during busy ignored", v, 8'h40);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        bus_write(2'd0, 8'h00);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h80;
        cmd_valid = 1'b1; cmd_bit = 3'd1; cmd_set = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        bus_read(2'd0, v); check(v == 8'h82, "R10 write then command", v, 8'h82);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_mux();
        t_drive_modes();
        t_pullup();
        t_addr3();
        t_rmw_hazard();
        t_write_inputs();
        t_stall();
        t_cmd_ignored();
        t_same_cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule